// File: doc/BRIEF.md
# Card Status Change Interrupt Controller

This block watches two active-low card-detect lines and one active-low general purpose input. It turns edges on them into sticky status bits. From those bits it drives an active-low interrupt request and an active-low wake (ring-indicate) output. It also issues a one-cycle configuration reset pulse when the card is withdrawn.

Software reaches three byte-wide registers through an indexed port: the event status register, the event enable register and the detect/general control register. Status bits can be acknowledged in two ways. Either a read of the status register clears them all, or writing a 1 clears the matching bit. A single input picks the scheme at run time. Software can also inject a card-detect event.

In resume mode, card-detect events light the wake output and hold it. They no longer drive the interrupt line.

Top module: `card_evt_ctrl`

## Requirements
- R1: After reset, irq_n and wake_n are 1, cfg_clr is 0, and every register reads 0.
- R2: Index 04h is the status register (bit3 card-detect change, bit4 GPI edge). Index 05h is the enable register (bit3 card-detect enable). Index 16h is control (bit1 config-reset enable, bit2 GPI enable, bit3 GPI polarity, bit4 resume, bit5 software trigger). Unused bits, bits 7:6, bit0 and unlisted indices read 0. reg_rdata follows reg_addr in the same cycle.
- R3: Each input passes through two sync flops. A change on either detect line sets status bit3 at the third rising clock edge after the change, but only while card-detect enable is 1.
- R4: While GPI enable is 1, a GPI edge sets status bit4: a high-to-low edge when polarity is 0, a low-to-high edge when polarity is 1. The other edge has no effect.
- R5: With ack_by_write = 0, a read strobe on index 04h clears all status bits and writes to 04h do nothing. With ack_by_write = 1, reads leave status intact and writing 1 to a status bit clears it. A new event in the same cycle wins over the clear.
- R6: Writing 1 to control bit5 while card-detect enable is 1 sets status bit3, the same as a hardware event. With enable 0 it has no effect. Bit5 always reads 0.
- R7: irq_n is 0 exactly when (bit3 and card-detect enable and not resume) or (bit4 and GPI enable).
- R8: wake_n is 0 exactly when status bit3 and resume are both 1. It stays 0 until bit3 is cleared.
- R9: With config-reset enable 1, cfg_clr is 1 for exactly one cycle when the two synchronized detect lines become both high. The delay matches R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_a_n | input | 1 | First card-detect line, low = seated |
| cd_b_n | input | 1 | Second card-detect line, low = seated |
| gpi_n | input | 1 | General purpose input |
| ack_by_write | input | 1 | 1 = write-one-to-clear, 0 = clear on status read |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears status in read-clear mode) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_n | output | 1 | Active-low interrupt request |
| wake_n | output | 1 | Active-low held wake output |
| cfg_clr | output | 1 | One-cycle configuration reset pulse |

## Verification
The detect lines are toggled one at a time, together and in sequence. This tells a single-line change apart from the both-high removal that must also fire the reset pulse. GPI is driven through both edges under each polarity, to show that only the chosen edge counts. Each acknowledge scheme is tried with reads, with writes of single bits and with writes in the wrong mode. Resume mode is run against the same detect changes, to separate the wake path from the interrupt path.

// File: rtl/card_evt_ctrl.sv
module card_evt_ctrl #(
  parameter logic [7:0] STAT_IDX = 8'h04,
  parameter logic [7:0] ENA_IDX  = 8'h05,
  parameter logic [7:0] CTRL_IDX = 8'h16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cd_a_n,
  input  logic       cd_b_n,
  input  logic       gpi_n,
  input  logic       ack_by_write,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_n,
  output logic       wake_n,
  output logic       cfg_clr
);

  // {gpi, cd_b, cd_a}: two sync stages plus one history stage
  logic [2:0] s1, s2, s3;
  logic st_cd, st_gp, cd_en;
  logic cfg_en, gpi_en, gpi_pol, resume;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 3'b111;
      s2 <= 3'b111;
      s3 <= 3'b111;
    end else begin
      s1 <= {gpi_n, cd_b_n, cd_a_n};
      s2 <= s1;
      s3 <= s2;
    end

  wire wr_st   = reg_wr && reg_addr == STAT_IDX;
  wire wr_ena  = reg_wr && reg_addr == ENA_IDX;
  wire wr_ctrl = reg_wr && reg_addr == CTRL_IDX;
  wire rd_st   = reg_rd && reg_addr == STAT_IDX;

  wire cd_chg  = (s2[0] ^ s3[0]) | (s2[1] ^ s3[1]);
  wire both_up = s2[0] & s2[1] & ~(s3[0] & s3[1]);
  wire gpi_ev  = gpi_pol ? (s2[2] & ~s3[2]) : (~s2[2] & s3[2]);
  wire sw_cd   = wr_ctrl & reg_wdata[5];

  wire set_cd  = cd_en & (cd_chg | sw_cd);
  wire set_gp  = gpi_en & gpi_ev;

  wire [7:0] clr = ack_by_write ? (wr_st ? reg_wdata : 8'h00)
                                : (rd_st ? 8'hFF : 8'h00);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_cd   <= 1'b0;
      st_gp   <= 1'b0;
      cd_en   <= 1'b0;
      cfg_en  <= 1'b0;
      gpi_en  <= 1'b0;
      gpi_pol <= 1'b0;
      resume  <= 1'b0;
      cfg_clr <= 1'b0;
    end else begin
      st_cd   <= set_cd | (st_cd & ~clr[3]);
      st_gp   <= set_gp | (st_gp & ~clr[4]);
      cfg_clr <= cfg_en & both_up;
      if (wr_ena) cd_en <= reg_wdata[3];
      if (wr_ctrl) begin
        cfg_en  <= reg_wdata[1];
        gpi_en  <= reg_wdata[2];
        gpi_pol <= reg_wdata[3];
        resume  <= reg_wdata[4];
      end
    end

  always_comb
    case (reg_addr)
      STAT_IDX: reg_rdata = {3'b000, st_gp, st_cd, 3'b000};
      ENA_IDX:  reg_rdata = {4'h0, cd_en, 3'b000};
      CTRL_IDX: reg_rdata = {3'b000, resume, gpi_pol, gpi_en, cfg_en, 1'b0};
      default:  reg_rdata = 8'h00;
    endcase

  assign irq_n  = ~((st_cd & cd_en & ~resume) | (st_gp & gpi_en));
  assign wake_n = ~(st_cd & resume);

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |=> !cfg_clr);

  p_wake_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_n && !clr[3] && !wr_ctrl) |=> !wake_n);

  p_resume_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && !(st_gp && gpi_en)) |-> irq_n);

  p_sw_bit_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_IDX) |-> !reg_rdata[5]);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !ack_by_write && !set_cd) |=> !st_cd);

  p_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_en && !st_cd) |=> !st_cd);

endmodule

// File: tb/tb_card_evt_ctrl.sv
module tb_card_evt_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cd_a_n = 1'b0, cd_b_n = 1'b0, gpi_n = 1'b1, ack_by_write = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic irq_n, wake_n, cfg_clr;

  always #4 clk = ~clk;

  card_evt_ctrl dut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model: delay lines hold each input as seen 1, 2, 3 edges back
  bit ha[3], hb[3], hg[3];
  bit m_cd, m_gp, m_en, m_cfg, m_gen, m_pol, m_res, m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin ha[i] = 1; hb[i] = 1; hg[i] = 1; end
      m_cd = 0; m_gp = 0; m_en = 0; m_cfg = 0; m_gen = 0; m_pol = 0; m_res = 0; m_clr = 0;
    end else begin
      bit cd_ev, gp_ev, up, sw, n_cd, n_gp;
      cd_ev = (ha[1] != ha[2]) || (hb[1] != hb[2]);
      up    = ha[1] && hb[1] && !(ha[2] && hb[2]);
      gp_ev = m_pol ? (hg[1] && !hg[2]) : (!hg[1] && hg[2]);
      sw    = reg_wr && reg_addr == 8'h16 && reg_wdata[5];
      n_cd = m_cd; n_gp = m_gp;
      if (ack_by_write && reg_wr && reg_addr == 8'h04) begin
        if (reg_wdata[3]) n_cd = 0;
        if (reg_wdata[4]) n_gp = 0;
      end
      if (!ack_by_write && reg_rd && reg_addr == 8'h04) begin n_cd = 0; n_gp = 0; end
      if (m_en && (cd_ev || sw)) n_cd = 1;
      if (m_gen && gp_ev) n_gp = 1;
      m_clr = m_cfg && up;
      m_cd = n_cd; m_gp = n_gp;
      if (reg_wr && reg_addr == 8'h05) m_en = reg_wdata[3];
      if (reg_wr && reg_addr == 8'h16) begin
        m_cfg = reg_wdata[1]; m_gen = reg_wdata[2]; m_pol = reg_wdata[3]; m_res = reg_wdata[4];
      end
      ha[2] = ha[1]; ha[1] = ha[0]; ha[0] = cd_a_n;
      hb[2] = hb[1]; hb[1] = hb[0]; hb[0] = cd_b_n;
      hg[2] = hg[1]; hg[1] = hg[0]; hg[0] = gpi_n;
    end
  end

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'h04:   return {3'b0, m_gp, m_cd, 3'b0};
      8'h05:   return {4'b0, m_en, 3'b0};
      8'h16:   return {3'b0, m_res, m_pol, m_gen, m_cfg, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("irq_n", {7'b0, irq_n}, {7'b0, !((m_cd && m_en && !m_res) || (m_gp && m_gen))});
    chk("wake_n", {7'b0, wake_n}, {7'b0, !(m_cd && m_res)});
    chk("cfg_clr", {7'b0, cfg_clr}, {7'b0, m_clr});
    chk("reg_rdata", reg_rdata, exp_rd(reg_addr));
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick(1);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a);
    reg_addr = a; reg_rd = 1;
    tick(1);
    reg_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    #20; @(posedge clk); #2; rst_n = 1;
    tick(5);
    rd(8'h04); rd(8'h05); rd(8'h16);

    cur_req = "R2";
    wr(8'h05, 8'hFF); reg_addr = 8'h05; tick(1);
    wr(8'h16, 8'hFF); reg_addr = 8'h16; tick(2);
    reg_addr = 8'h20; tick(1);
    wr(8'h16, 8'h00); rd(8'h04); tick(2);

    cur_req = "R3";
    cd_a_n = 1; reg_addr = 8'h04; tick(5);
    rd(8'h04); tick(2);
    cd_b_n = 1; tick(5); rd(8'h04);
    cd_a_n = 0; cd_b_n = 0; tick(5); rd(8'h04);
    wr(8'h05, 8'h00);
    cd_b_n = 1; tick(5); cd_b_n = 0; tick(5); reg_addr = 8'h04; tick(1);
    wr(8'h05, 8'h08);

    cur_req = "R4";
    wr(8'h16, 8'h04);
    gpi_n = 0; reg_addr = 8'h04; tick(5);
    gpi_n = 1; tick(5);
    rd(8'h04); tick(1);
    wr(8'h16, 8'h0C);
    gpi_n = 0; tick(5);
    gpi_n = 1; tick(5); rd(8'h04);
    wr(8'h16, 8'h00); gpi_n = 0; tick(5); gpi_n = 1; tick(5);

    cur_req = "R5";
    ack_by_write = 1;
    wr(8'h16, 8'h04); gpi_n = 0; cd_a_n = 1; tick(5);
    rd(8'h04); rd(8'h04);
    wr(8'h04, 8'h10); reg_addr = 8'h04; tick(1);
    wr(8'h04, 8'h08); reg_addr = 8'h04; tick(1);
    ack_by_write = 0;
    cd_a_n = 0; tick(5);
    wr(8'h04, 8'h18); reg_addr = 8'h04; tick(1);
    rd(8'h04);
    cd_a_n = 1; tick(3); rd(8'h04); tick(3); rd(8'h04);

    cur_req = "R6";
    wr(8'h16, 8'h20); reg_addr = 8'h16; tick(1); reg_addr = 8'h04; tick(1);
    rd(8'h04);
    wr(8'h05, 8'h00); wr(8'h16, 8'h20); reg_addr = 8'h04; tick(2);
    wr(8'h05, 8'h08);

    cur_req = "R7";
    wr(8'h16, 8'h20); tick(2); rd(8'h04); tick(1);

    cur_req = "R8";
    wr(8'h16, 8'h10);
    cd_a_n = 0; tick(5); tick(4);
    ack_by_write = 1;
    wr(8'h04, 8'h08); tick(2);
    wr(8'h16, 8'h30); tick(2);
    wr(8'h16, 8'h00); tick(2);
    wr(8'h04, 8'h08);
    ack_by_write = 0;

    cur_req = "R9";
    wr(8'h16, 8'h02);
    cd_a_n = 1; cd_b_n = 1; tick(6);
    cd_a_n = 0; cd_b_n = 0; tick(5);
    cd_a_n = 1; tick(4); cd_b_n = 1; tick(6);
    cd_a_n = 0; cd_b_n = 0; wr(8'h16, 8'h00); tick(5);
    cd_a_n = 1; cd_b_n = 1; tick(6);
    rd(8'h04); tick(3);

    finish_run();
  end
endmodule